// File: doc/BRIEF.md
# Fixed-Point Passive Compartment Stepper

This block advances one passive neuron compartment by one forward-Euler step each time it receives a step strobe. The compartment has a leak conductance toward a resting potential and a current source that is active only inside a fixed window of simulated time. It also has an excitatory synapse whose conductance is the difference of two exponentially decaying variables: a fast one, A, with a 1.5 ms time constant, and a slow one, B, with a 5 ms time constant. The step is 0.1 ms and the capacitance is 10 pF. All of the arithmetic is integer, and every constant has been pre-scaled so that the engine needs no floating point.

The membrane voltage is a 32-bit signed word in which one volt equals 2^28 LSB, so the word spans ±8 V at full scale. The two synaptic variables are 32-bit signed words in which 1.0 equals 2^24 LSB. One update uses five products, and a single shared multiplier computes them in sequence under a small phase sequencer. A spike-input pulse marks a pending event. At the end of the next update that event adds 1.0 to both synaptic variables. A surrounding simulation loop drives the step strobe, waits for the done pulse and then reads the voltage and the step counter.

Top module: `pcell_euler`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, v_out is -17179869 (-64 mV), t_out is 0 and step_done is 0; A and B are 0.
- R2: A step strobe sampled while the engine is idle starts one update, and step_done rises for exactly one cycle 7 clock edges after that sample. Strobes sampled during an update are ignored. The done cycle counts as idle.
- R3: t_out increases by exactly 1 per completed update, in the cycle where step_done is high. Neither t_out nor v_out changes in any other cycle.
- R4: One update computes V' = V + dL + dS + dI, wrapping to 32 bits. Here dL = floor(20972 * (-17179869 - V) / 2^20), which gives a per-step leak gain of 0.02.
- R5: dI is 80531 (30 pA over one step) when the pre-update step count t satisfies 500 < t < 1000, and 0 for every other t, including 500 and 1000.
- R6: The synaptic term uses P = floor((B - A) * (-V) / 2^24) and dS = floor(3146 * P / 2^20). A spike therefore pulls V up from rest.
- R7: Each update decays the synaptic variables as A' = A - floor(69905 * A / 2^20) and B' = B - floor(20972 * B / 2^20).
- R8: A pending spike adds 2^24 to both A and B only after the Euler terms of that update have been formed. The voltage change of that update uses the pre-spike A and B.
- R9: A spike pulse is latched until the next update commits. Several pulses before one commit add 2^24 only once. A pulse in the commit cycle itself is kept for the following update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step strobe, one update per accepted pulse |
| spike_i | input | 1 | Spike-input pulse, latched until the next commit |
| v_out | output | 32 | Membrane voltage, signed, 2^28 LSB per volt |
| t_out | output | 32 | Count of completed updates |
| step_done | output | 1 | One-cycle pulse after each update commits |

## Verification
The assertions check the sequencing contract on every cycle. An accepted strobe is followed by a done pulse exactly seven edges later, every done pulse has an accepted strobe behind it, and the done pulse is a single cycle. t_out moves by exactly one at done and holds otherwise, and v_out changes only at done. The arithmetic itself can only be shown by the bench's scenarios, which compare every update against an independent integer model. Those scenarios cover the exact edges of the injection window, the order of the spike increment relative to the Euler terms, the merging of repeated spike pulses, and the decay that follows a spike.

// File: rtl/pcell_pkg.sv
package pcell_pkg;

   // Phases of one update; each non-idle phase issues one product to the shared multiplier.
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LEAK   = 3'd1,   // issue leak product
      PH_SPROD  = 3'd2,   // issue (B-A)*(-V), capture leak result
      PH_DECA   = 3'd3,   // issue fast decay, capture synaptic product
      PH_DECB   = 3'd4,   // issue slow decay, capture fast decay
      PH_SSCALE = 3'd5,   // issue synaptic scaling, capture slow decay
      PH_COMMIT = 3'd6    // multiplier holds scaled synaptic term; commit state
   } phase_t;

   localparam int N_SYN    = 2;
   localparam int SYN_FAST = 0;
   localparam int SYN_SLOW = 1;

endpackage

// File: rtl/pcell_seq.sv
module pcell_seq
   import pcell_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   step_i,
   output phase_t phase_o,
   output logic   idle_o,
   output logic   done_o
);

   phase_t ph_q;
   phase_t ph_n;
   logic   done_q;

   always_comb begin
      case (ph_q)
         PH_IDLE:   ph_n = step_i ? PH_LEAK : PH_IDLE;
         PH_LEAK:   ph_n = PH_SPROD;
         PH_SPROD:  ph_n = PH_DECA;
         PH_DECA:   ph_n = PH_DECB;
         PH_DECB:   ph_n = PH_SSCALE;
         PH_SSCALE: ph_n = PH_COMMIT;
         PH_COMMIT: ph_n = PH_IDLE;
         default:   ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q   <= PH_IDLE;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_n;
         done_q <= (ph_q == PH_COMMIT);
      end
   end

   assign phase_o = ph_q;
   assign idle_o  = (ph_q == PH_IDLE);
   assign done_o  = done_q;

endmodule

// File: rtl/pcell_mul.sv
module pcell_mul #(
   parameter int OP_W  = 33,
   parameter int RES_W = 32,
   parameter int SH_LO = 20,
   parameter int SH_HI = 24
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [OP_W-1:0]  a_i,
   input  logic signed [OP_W-1:0]  b_i,
   input  logic                    sel_hi_i,
   output logic signed [RES_W-1:0] q_o
);

   localparam int PROD_W = 2 * OP_W;

   logic signed [PROD_W-1:0] prod;

   // Sign-extend both operands to full product width; the low PROD_W bits are the exact signed product.
   assign prod = $signed({{OP_W{a_i[OP_W-1]}}, a_i} * {{OP_W{b_i[OP_W-1]}}, b_i});

   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= '0;
      end else if (sel_hi_i) begin
         q_o <= RES_W'(prod >>> SH_HI);
      end else begin
         q_o <= RES_W'(prod >>> SH_LO);
      end
   end

endmodule

// File: rtl/pcell_state.sv
module pcell_state
   import pcell_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int T_W          = 32,
   parameter int OP_W         = 33,
   parameter int SYN_FRAC     = 24,
   parameter int V_REST       = -17179869,
   parameter int K_LEAK       = 20972,
   parameter int K_SYN        = 3146,
   parameter int K_DECAY_FAST = 69905,
   parameter int K_DECAY_SLOW = 20972,
   parameter int INJ_DV       = 80531,
   parameter int INJ_LO       = 500,
   parameter int INJ_HI       = 1000
) (
   input  logic                     clk,
   input  logic                     rst,
   input  phase_t                   phase_i,
   input  logic                     spike_i,
   input  logic signed [DATA_W-1:0] mul_q_i,
   output logic signed [OP_W-1:0]   mul_a_o,
   output logic signed [OP_W-1:0]   mul_b_o,
   output logic                     mul_hi_o,
   output logic signed [DATA_W-1:0] v_o,
   output logic [T_W-1:0]           t_o
);

   localparam logic signed [DATA_W-1:0] VREST_D = DATA_W'(V_REST);
   localparam logic signed [DATA_W-1:0] INJ_D   = DATA_W'(INJ_DV);
   localparam logic signed [DATA_W-1:0] SPK_D   = DATA_W'(1) << SYN_FRAC;
   localparam logic signed [OP_W-1:0]   KL_OP   = OP_W'(K_LEAK);
   localparam logic signed [OP_W-1:0]   KS_OP   = OP_W'(K_SYN);
   localparam logic signed [OP_W-1:0]   KDF_OP  = OP_W'(K_DECAY_FAST);
   localparam logic signed [OP_W-1:0]   KDS_OP  = OP_W'(K_DECAY_SLOW);
   localparam logic [T_W-1:0]           LO_T    = T_W'(INJ_LO);
   localparam logic [T_W-1:0]           HI_T    = T_W'(INJ_HI);

   logic signed [DATA_W-1:0] v_q;
   logic [T_W-1:0]           t_q;
   logic signed [DATA_W-1:0] dleak_q;
   logic signed [DATA_W-1:0] sprod_q;
   logic                     pend_q;
   logic [N_SYN-1:0][DATA_W-1:0] syn_w;

   logic signed [OP_W-1:0]   v_x;
   logic signed [OP_W-1:0]   vr_x;
   logic signed [OP_W-1:0]   sf_x;
   logic signed [OP_W-1:0]   ss_x;
   logic signed [OP_W-1:0]   sp_x;
   logic                     in_win;
   logic signed [DATA_W-1:0] inj_v;
   logic                     commit;

   assign commit = (phase_i == PH_COMMIT);
   assign v_x    = {v_q[DATA_W-1], v_q};
   assign vr_x   = {VREST_D[DATA_W-1], VREST_D};
   assign sf_x   = {syn_w[SYN_FAST][DATA_W-1], syn_w[SYN_FAST]};
   assign ss_x   = {syn_w[SYN_SLOW][DATA_W-1], syn_w[SYN_SLOW]};
   assign sp_x   = {sprod_q[DATA_W-1], sprod_q};

   // Operand selection for the shared multiplier
   always_comb begin
      mul_a_o  = '0;
      mul_b_o  = '0;
      mul_hi_o = 1'b0;
      case (phase_i)
         PH_LEAK: begin
            mul_a_o = vr_x - v_x;
            mul_b_o = KL_OP;
         end
         PH_SPROD: begin
            mul_a_o  = ss_x - sf_x;
            mul_b_o  = -v_x;
            mul_hi_o = 1'b1;
         end
         PH_DECA: begin
            mul_a_o = sf_x;
            mul_b_o = KDF_OP;
         end
         PH_DECB: begin
            mul_a_o = ss_x;
            mul_b_o = KDS_OP;
         end
         PH_SSCALE: begin
            mul_a_o = sp_x;
            mul_b_o = KS_OP;
         end
         default: begin
            mul_a_o  = '0;
            mul_b_o  = '0;
            mul_hi_o = 1'b0;
         end
      endcase
   end

   // Injection window is open strictly between the two bounds
   assign in_win = (t_q > LO_T) && (t_q < HI_T);
   assign inj_v  = in_win ? INJ_D : '0;

   // Voltage, step counter, intermediates and spike latch
   always_ff @(posedge clk) begin
      if (rst) begin
         v_q     <= VREST_D;
         t_q     <= '0;
         dleak_q <= '0;
         sprod_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (phase_i == PH_SPROD) dleak_q <= mul_q_i;
         if (phase_i == PH_DECA)  sprod_q <= mul_q_i;
         if (commit) begin
            v_q    <= v_q + dleak_q + mul_q_i + inj_v;
            t_q    <= t_q + T_W'(1);
            pend_q <= spike_i;
         end else if (spike_i) begin
            pend_q <= 1'b1;
         end
      end
   end

   // One decaying synaptic variable per time constant
   for (genvar gi = 0; gi < N_SYN; gi++) begin : g_syn
      localparam phase_t CAP_PH = (gi == SYN_FAST) ? PH_DECB : PH_SSCALE;

      logic signed [DATA_W-1:0] s_q;
      logic signed [DATA_W-1:0] dec_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            s_q   <= '0;
            dec_q <= '0;
         end else begin
            if (phase_i == CAP_PH) dec_q <= mul_q_i;
            if (commit) s_q <= s_q - dec_q + (pend_q ? SPK_D : '0);
         end
      end

      assign syn_w[gi] = s_q;
   end

   assign v_o = v_q;
   assign t_o = t_q;

endmodule

// File: rtl/pcell_euler.sv
module pcell_euler
   import pcell_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int T_W          = 32,
   parameter int COEF_SHIFT   = 20,
   parameter int SYN_FRAC     = 24,
   parameter int V_REST       = -17179869,
   parameter int K_LEAK       = 20972,
   parameter int K_SYN        = 3146,
   parameter int K_DECAY_FAST = 69905,
   parameter int K_DECAY_SLOW = 20972,
   parameter int INJ_DV       = 80531,
   parameter int INJ_LO       = 500,
   parameter int INJ_HI       = 1000
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     step_i,
   input  logic                     spike_i,
   output logic signed [DATA_W-1:0] v_out,
   output logic [T_W-1:0]           t_out,
   output logic                     step_done
);

   localparam int     OP_W    = DATA_W + 1;
   localparam longint COEF_MX = longint'(1) << (DATA_W - 2);

   initial begin
      assert (DATA_W >= 16 && DATA_W <= 32)
         else $error("pcell_euler: DATA_W out of range");
      assert (T_W >= 2 && T_W <= 32)
         else $error("pcell_euler: T_W out of range");
      assert (COEF_SHIFT > 0 && SYN_FRAC > 0 && SYN_FRAC < DATA_W - 1)
         else $error("pcell_euler: shift amounts out of range");
      assert (INJ_LO < INJ_HI)
         else $error("pcell_euler: injection window empty");
      assert (longint'(K_LEAK) < COEF_MX && longint'(K_SYN) < COEF_MX
              && longint'(K_DECAY_FAST) < COEF_MX && longint'(K_DECAY_SLOW) < COEF_MX)
         else $error("pcell_euler: coefficient too wide");
   end

   phase_t                   phase;
   logic                     seq_idle;
   logic signed [OP_W-1:0]   mul_a;
   logic signed [OP_W-1:0]   mul_b;
   logic                     mul_hi;
   logic signed [DATA_W-1:0] mul_q;

   pcell_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_i),
      .phase_o (phase),
      .idle_o  (seq_idle),
      .done_o  (step_done)
   );

   pcell_mul #(
      .OP_W  (OP_W),
      .RES_W (DATA_W),
      .SH_LO (COEF_SHIFT),
      .SH_HI (SYN_FRAC)
   ) u_mul (
      .clk      (clk),
      .rst      (rst),
      .a_i      (mul_a),
      .b_i      (mul_b),
      .sel_hi_i (mul_hi),
      .q_o      (mul_q)
   );

   pcell_state #(
      .DATA_W       (DATA_W),
      .T_W          (T_W),
      .OP_W         (OP_W),
      .SYN_FRAC     (SYN_FRAC),
      .V_REST       (V_REST),
      .K_LEAK       (K_LEAK),
      .K_SYN        (K_SYN),
      .K_DECAY_FAST (K_DECAY_FAST),
      .K_DECAY_SLOW (K_DECAY_SLOW),
      .INJ_DV       (INJ_DV),
      .INJ_LO       (INJ_LO),
      .INJ_HI       (INJ_HI)
   ) u_state (
      .clk      (clk),
      .rst      (rst),
      .phase_i  (phase),
      .spike_i  (spike_i),
      .mul_q_i  (mul_q),
      .mul_a_o  (mul_a),
      .mul_b_o  (mul_b),
      .mul_hi_o (mul_hi),
      .v_o      (v_out),
      .t_o      (t_out)
   );

endmodule

// File: rtl/pcell_checker.sv
module pcell_checker #(
   parameter int DATA_W = 32,
   parameter int T_W    = 32
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     step_i,
   input logic                     idle,
   input logic signed [DATA_W-1:0] v_out,
   input logic [T_W-1:0]           t_out,
   input logic                     step_done
);

   // R1: state right after reset release
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (t_out == '0 && !step_done));

   // R2: accepted strobe yields done seven edges later
   a_r2_done_latency: assert property (@(posedge clk) disable iff (rst)
      (step_i && idle) |-> ##7 step_done);

   // R2: every done pulse traces back to an accepted strobe
   a_r2_done_cause: assert property (@(posedge clk) disable iff (rst)
      step_done |-> $past(step_i && idle, 7));

   // R2: done lasts one cycle
   a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
      step_done |=> !step_done);

   // R3: counter advances by one at done
   a_r3_t_advance: assert property (@(posedge clk) disable iff (rst)
      step_done |-> (t_out == $past(t_out) + T_W'(1)));

   // R3: counter holds between updates
   a_r3_t_hold: assert property (@(posedge clk) disable iff (rst)
      !step_done |-> $stable(t_out));

   // R3: voltage holds between updates
   a_r3_v_hold: assert property (@(posedge clk) disable iff (rst)
      !step_done |-> $stable(v_out));

endmodule

bind pcell_euler pcell_checker #(
   .DATA_W (DATA_W),
   .T_W    (T_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .step_i    (step_i),
   .idle      (seq_idle),
   .v_out     (v_out),
   .t_out     (t_out),
   .step_done (step_done)
);

// File: tb/pcell_euler_test.sv
module pcell_euler_test;

   localparam int VREST = -17179869;
   localparam int INJ   = 80531;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst     = 1'b1;
   logic               step_i  = 1'b0;
   logic               spike_i = 1'b0;
   logic signed [31:0] v_out;
   logic [31:0]        t_out;
   logic               step_done;

   pcell_euler uut (
      .clk       (clk),
      .rst       (rst),
      .step_i    (step_i),
      .spike_i   (spike_i),
      .v_out     (v_out),
      .t_out     (t_out),
      .step_done (step_done)
   );

   int    checks    = 0;
   int    errors    = 0;
   int    issued    = 0;
   int    completed = 0;
   bit    finished  = 1'b0;
   int    qv[$];
   int    qt[$];
   string qs[$];

   int mv, ma, mb, mt;
   bit mpend;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      mv = VREST; ma = 0; mb = 0; mt = 0; mpend = 1'b0;
   endtask

   // Independent integer model of one update, pushed to the scoreboard
   task automatic model_step(input string tag);
      int dl, pr, ds, da, db, di;
      dl = int'(((longint'(VREST) - longint'(mv)) * 20972) >>> 20);
      pr = int'(((longint'(mb) - longint'(ma)) * (-longint'(mv))) >>> 24);
      ds = int'((longint'(pr) * 3146) >>> 20);
      da = int'((longint'(ma) * 69905) >>> 20);
      db = int'((longint'(mb) * 20972) >>> 20);
      di = (mt > 500 && mt < 1000) ? INJ : 0;
      mv = mv + dl + ds + di;
      ma = ma - da + (mpend ? (1 << 24) : 0);
      mb = mb - db + (mpend ? (1 << 24) : 0);
      mpend = 1'b0;
      mt++;
      qv.push_back(mv);
      qt.push_back(mt);
      qs.push_back(tag);
      issued++;
   endtask

   task automatic wait_done();
      while (completed < issued) @(negedge clk);
   endtask

   task automatic do_step(input string tag);
      @(negedge clk); step_i = 1'b1;
      @(negedge clk); step_i = 1'b0;
      model_step(tag);
      wait_done();
   endtask

   task automatic do_step_twice(input string tag);
      @(negedge clk); step_i = 1'b1;
      @(negedge clk); step_i = 1'b0;
      @(negedge clk);
      @(negedge clk); step_i = 1'b1;
      @(negedge clk); step_i = 1'b0;
      model_step(tag);
      wait_done();
      repeat (10) @(negedge clk);
      chk("R2 second strobe ignored, t_out", t_out, mt);
   endtask

   task automatic spike_pulse();
      @(negedge clk); spike_i = 1'b1;
      @(negedge clk); spike_i = 1'b0;
      mpend = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
      issued = 0;
      completed = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Monitor: compare each completed update with the scoreboard head
   always @(negedge clk) begin
      if (!rst && step_done) begin
         if (qv.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2 unexpected step_done actual=1 expected=0");
         end else begin
            chk({qs[0], " v_out"}, v_out, qv[0]);
            chk({"R3 ", qs[0], " t_out"}, t_out, qt[0]);
            void'(qv.pop_front());
            void'(qt.pop_front());
            void'(qs.pop_front());
            completed++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset v_out", v_out, VREST);
      chk("R1 reset t_out", t_out, 0);
      chk("R1 reset step_done", step_done, 0);

      // Rest and injection window without spikes
      for (int i = 0; i < 501; i++) do_step("R4 R5 before window");
      chk("R5 t=500 outside window v_out", v_out, VREST);
      chk("R3 t_out after 501 steps", t_out, 501);
      do_step("R5 first window step");
      chk("R5 first injected step v_out", v_out, VREST + INJ);
      for (int i = 0; i < 500; i++) do_step("R4 R5 window and leak");

      // Single spike from rest
      do_reset();
      spike_pulse();
      do_step("R8 spike step");
      chk("R8 update uses pre-spike A B", v_out, VREST);
      do_step("R8 equal A B");
      chk("R8 equal A and B give no synaptic term", v_out, VREST);
      for (int i = 0; i < 20; i++) do_step("R6 R7 synaptic decay");
      chk("R6 synapse depolarizes", (v_out > VREST) ? 1 : 0, 1);

      // Repeated pulses merge into one increment, latched across idle cycles
      do_reset();
      spike_pulse();
      spike_pulse();
      repeat (5) @(negedge clk);
      do_step("R9 merged spikes");
      for (int i = 0; i < 10; i++) do_step("R9 R7 after merged spikes");

      // Strobes during an update
      do_step_twice("R2 ignored strobe A");
      do_step_twice("R2 ignored strobe B");

      repeat (12) @(negedge clk);
      chk("R2 no stray done, scoreboard empty", qv.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule